// File: doc/BRIEF.md
# Receive Event Interrupt Flag Register

This block keeps sticky interrupt flags for a packet radio receiver. The receive datapath sends it single-cycle event pulses for five moments in a reception: a valid preamble, a matched sync word, a matched node address, a good CRC, and the end of a packet. Each event can latch its own flag, but only while the matching enable bit is set. The node address, CRC and end-of-packet flags also require packet mode.

Software uses a small write port to program the enable mask at one address. It clears flags by writing ones to a second address, where every bit acts as a one-cycle strobe. The five flags are presented together as a read-only status byte. A single interrupt line is high while any flag is set.

Top module: `rx_event_irq`

## Requirements
- R1: After reset, every status bit, every enable bit and the interrupt output are 0.
- R2: A preamble event sets status bit 4 when enable bit 4 is 1, in either mode. The bit then stays 1 until it is cleared.
- R3: A sync-word event sets status bit 3 when enable bit 3 is 1, in either mode. The bit is sticky in the same way as R2.
- R4: A node-address event sets status bit 2 only when pkt_mode is 1 and enable bit 2 is 1. In FIFO mode (pkt_mode 0) the event is ignored.
- R5: A CRC-good event sets status bit 1 only when pkt_mode is 1 and enable bit 1 is 1.
- R6: An end-of-packet event sets status bit 0 when pkt_mode is 1 and enable bit 0 is 1. This happens whether or not a CRC-good event was seen for that packet.
- R7: An event whose enable bit is 0 leaves the status unchanged.
- R8: A write to address 1 (clear) clears each flag whose data bit is 1, using the same bit layout as the status. Data bits that are 0 leave their flags unchanged, and the clear is not remembered after the write cycle.
- R9: When a flag's set event and a clear write for that flag fall in the same cycle, the flag ends up set.
- R10: irq is 1 exactly when at least one status bit is 1.
- R11: Status bits 7 to 5 always read 0.
- R12: A write to address 0 loads the enable mask, using the same bit layout as the status. Clearing an enable bit does not clear a flag that is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_mode | input | 1 | 1 = packet mode, 0 = FIFO mode |
| ev_preamble | input | 1 | Preamble-valid pulse |
| ev_sync | input | 1 | Sync-word-match pulse |
| ev_node | input | 1 | Node-address-match pulse |
| ev_crc | input | 1 | CRC-good pulse |
| ev_pkt_done | input | 1 | End-of-packet pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = enable mask, 1 = clear strobes |
| wr_data | input | 8 | Write data |
| status | output | 8 | Sticky flag byte |
| irq | output | 1 | OR of all flags |

## Verification
The assertions are checked on every cycle for each flag cell:
- a flag never rises without a set request;
- a flag never falls without a clear;
- a set request always leaves the flag set, even when a clear arrives in the same cycle.

At the top level, further assertions tie each rising status bit to its event pulse in the cycle before, and to packet mode for the three packet-only flags.

Some behaviours can only be shown by the bench's scenarios, because each one is a sequence of writes and events whose result is a whole status byte:
- enable masking;
- selective clears;
- that writing zeros changes nothing;
- that removing an enable keeps existing flags;
- the full byte after mixed-mode traffic.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;
   localparam int FLAG_COUNT = 5;
   localparam int IDX_DONE     = 0;
   localparam int IDX_CRC      = 1;
   localparam int IDX_NODE     = 2;
   localparam int IDX_SYNC     = 3;
   localparam int IDX_PREAMBLE = 4;
   // flags that may only latch in packet mode
   localparam logic [FLAG_COUNT-1:0] PKT_ONLY_MASK = 5'b00111;
endpackage

// File: rtl/rxirq_ctrl_regs.sv
module rxirq_ctrl_regs #(
   parameter int FLAGS   = 5,
   parameter int ADDR_W  = 1,
   parameter int EN_ADDR = 0,
   parameter int CLR_ADDR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [FLAGS-1:0]  wr_bits,
   output logic [FLAGS-1:0]  enable,
   output logic [FLAGS-1:0]  clr_stb
);
   localparam logic [ADDR_W-1:0] EN_A  = ADDR_W'(EN_ADDR);
   localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_ADDR);

   generate
      if (EN_ADDR == CLR_ADDR) begin : g_bad_map
         $error("rxirq_ctrl_regs: enable and clear addresses collide");
      end
   endgenerate

   logic hit_en, hit_clr;
   assign hit_en  = wr_en && (wr_addr == EN_A);
   assign hit_clr = wr_en && (wr_addr == CLR_A);

   always_ff @(posedge clk) begin
      if (!rst_n)      enable <= '0;
      else if (hit_en) enable <= wr_bits;
   end

   // self-resetting strobes: only live during the write cycle
   assign clr_stb = hit_clr ? wr_bits : '0;

   a_r12_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
      hit_en |=> (enable == $past(wr_bits)));
   a_r12_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_en |=> $stable(enable));
endmodule

// File: rtl/rxirq_mode_gate.sv
module rxirq_mode_gate #(
   parameter int FLAGS = 5,
   parameter logic [FLAGS-1:0] MODE_MASK = '0
) (
   input  logic             pkt_mode,
   input  logic [FLAGS-1:0] events,
   input  logic [FLAGS-1:0] enable,
   output logic [FLAGS-1:0] set_req
);
   generate
      for (genvar i = 0; i < FLAGS; i++) begin : g_lane
         if (MODE_MASK[i]) begin : g_pkt_only
            assign set_req[i] = events[i] & enable[i] & pkt_mode;
         end else begin : g_any_mode
            assign set_req[i] = events[i] & enable[i];
         end
      end
   endgenerate
endmodule

// File: rtl/rxirq_sticky_flag.sv
module rxirq_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_req,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (!rst_n)       flag <= 1'b0;
      else if (set_req) flag <= 1'b1;   // set beats clear
      else if (clr_req) flag <= 1'b0;
   end

   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_req |=> flag);
   a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !set_req) |=> !flag);
   a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr_req) |=> flag);
   a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag && !set_req) |=> !flag);
endmodule

// File: rtl/rx_event_irq.sv
module rx_event_irq
   import rxirq_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 1,
   parameter int EN_ADDR  = 0,
   parameter int CLR_ADDR = 1,
   parameter bit REG_IRQ  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_mode,
   input  logic              ev_preamble,
   input  logic              ev_sync,
   input  logic              ev_node,
   input  logic              ev_crc,
   input  logic              ev_pkt_done,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] status,
   output logic              irq
);
   localparam int PAD_W = DATA_W - FLAG_COUNT;

   generate
      if (DATA_W <= FLAG_COUNT) begin : g_bad_width
         $error("rx_event_irq: DATA_W must exceed the flag count");
      end
      if (ADDR_W < 1 || (1 << ADDR_W) <= EN_ADDR || (1 << ADDR_W) <= CLR_ADDR) begin : g_bad_addr
         $error("rx_event_irq: register addresses do not fit ADDR_W");
      end
   endgenerate

   logic [FLAG_COUNT-1:0] events, enable, clr_stb, set_req, flags;
   logic                  unused_hi_bits;

   assign unused_hi_bits = ^wr_data[DATA_W-1:FLAG_COUNT];

   always_comb begin
      events               = '0;
      events[IDX_PREAMBLE] = ev_preamble;
      events[IDX_SYNC]     = ev_sync;
      events[IDX_NODE]     = ev_node;
      events[IDX_CRC]      = ev_crc;
      events[IDX_DONE]     = ev_pkt_done;
   end

   rxirq_ctrl_regs #(
      .FLAGS(FLAG_COUNT), .ADDR_W(ADDR_W), .EN_ADDR(EN_ADDR), .CLR_ADDR(CLR_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_bits(wr_data[FLAG_COUNT-1:0]), .enable(enable), .clr_stb(clr_stb)
   );

   rxirq_mode_gate #(.FLAGS(FLAG_COUNT), .MODE_MASK(PKT_ONLY_MASK)) u_gate (
      .pkt_mode(pkt_mode), .events(events), .enable(enable), .set_req(set_req)
   );

   generate
      for (genvar i = 0; i < FLAG_COUNT; i++) begin : g_flag
         rxirq_sticky_flag u_flag (
            .clk(clk), .rst_n(rst_n), .set_req(set_req[i]),
            .clr_req(clr_stb[i]), .flag(flags[i])
         );
      end
   endgenerate

   assign status = {{PAD_W{1'b0}}, flags};

   generate
      if (REG_IRQ) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |flags;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = |flags;
      end
   endgenerate

   a_r2_preamble_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[IDX_PREAMBLE]) |-> $past(ev_preamble));
   a_r3_sync_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[IDX_SYNC]) |-> $past(ev_sync));
   a_r4_node_needs_pkt: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[IDX_NODE]) |-> $past(ev_node && pkt_mode));
   a_r5_crc_needs_pkt: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[IDX_CRC]) |-> $past(ev_crc && pkt_mode));
   a_r6_done_needs_pkt: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[IDX_DONE]) |-> $past(ev_pkt_done && pkt_mode));
endmodule

// File: tb/rx_event_irq_bench.sv
module rx_event_irq_bench;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       pkt_mode;
   logic       ev_preamble, ev_sync, ev_node, ev_crc, ev_pkt_done;
   logic       wr_en;
   logic [0:0] wr_addr;
   logic [7:0] wr_data;
   logic [7:0] status;
   logic       irq;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;   // 125 MHz

   rx_event_irq u_rx_event_irq (
      .clk(clk), .rst_n(rst_n), .pkt_mode(pkt_mode),
      .ev_preamble(ev_preamble), .ev_sync(ev_sync), .ev_node(ev_node),
      .ev_crc(ev_crc), .ev_pkt_done(ev_pkt_done),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .status(status), .irq(irq)
   );

   // {mode, enable[4:0], events[4:0], clear[4:0], expected[4:0]}
   // event bit order: 4 preamble, 3 sync, 2 node, 1 crc, 0 done
   localparam int NV = 15;
   localparam logic [20:0] VEC [NV] = '{
      {1'b1, 5'h1F, 5'h10, 5'h00, 5'h10},  // R2
      {1'b1, 5'h1F, 5'h08, 5'h00, 5'h18},  // R3
      {1'b0, 5'h1F, 5'h04, 5'h00, 5'h18},  // R4 fifo mode ignored
      {1'b1, 5'h1F, 5'h04, 5'h00, 5'h1C},  // R4
      {1'b0, 5'h1F, 5'h02, 5'h00, 5'h1C},  // R5 fifo mode ignored
      {1'b1, 5'h1F, 5'h02, 5'h00, 5'h1E},  // R5
      {1'b0, 5'h1F, 5'h01, 5'h00, 5'h1E},  // R6 fifo mode ignored
      {1'b1, 5'h1F, 5'h01, 5'h00, 5'h1F},  // R6 done without crc
      {1'b1, 5'h1F, 5'h00, 5'h1F, 5'h00},  // R8 clear all
      {1'b1, 5'h00, 5'h1F, 5'h00, 5'h00},  // R7 all disabled
      {1'b1, 5'h0F, 5'h1F, 5'h00, 5'h0F},  // R7 preamble disabled
      {1'b1, 5'h00, 5'h00, 5'h00, 5'h0F},  // R12 enables off keep flags
      {1'b1, 5'h00, 5'h00, 5'h05, 5'h0A},  // R8 selective clear
      {1'b1, 5'h1F, 5'h0A, 5'h0A, 5'h0A},  // R9 set beats clear
      {1'b0, 5'h1F, 5'h1F, 5'h00, 5'h1A}   // R4 R5 R6 gated, R2 R3 set
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 8'h00;
   endtask

   task automatic pulse(input logic mode, input logic [4:0] ev, input logic [4:0] clr);
      @(negedge clk);
      pkt_mode = mode;
      {ev_preamble, ev_sync, ev_node, ev_crc, ev_pkt_done} = ev;
      if (clr != 5'h00) begin
         wr_en = 1'b1; wr_addr = 1'b1; wr_data = {3'b000, clr};
      end
      @(negedge clk);
      {ev_preamble, ev_sync, ev_node, ev_crc, ev_pkt_done} = 5'h00;
      wr_en = 1'b0; wr_data = 8'h00;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      rst_n = 1'b0; pkt_mode = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = 8'h00;
      {ev_preamble, ev_sync, ev_node, ev_crc, ev_pkt_done} = 5'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 status", status, 8'h00);
      check("R1 irq", {7'b0, irq}, 8'h00);
      // R1: enables reset to 0, so an event without a write does nothing
      pulse(1'b1, 5'h1F, 5'h00);
      check("R1 enables", status, 8'h00);

      for (int i = 0; i < NV; i++) begin
         reg_write(1'b0, {3'b000, VEC[i][19:15]});
         pulse(VEC[i][20], VEC[i][14:10], VEC[i][9:5]);
         check($sformatf("vec%0d status", i), status, {3'b000, VEC[i][4:0]});
         check($sformatf("vec%0d R10 irq", i), {7'b0, irq}, {7'b0, |VEC[i][4:0]});
         check($sformatf("vec%0d R11 upper", i), {5'b0, status[7:5]}, 8'h00);
      end

      // R8: writing zeros to the clear address changes nothing
      reg_write(1'b1, 8'h00);
      check("R8 zero write", status, 8'h1A);
      // R8: clear strobe does not persist; new event after clear sets again
      reg_write(1'b1, 8'h1F);
      check("R8 clear all", status, 8'h00);
      check("R10 irq low", {7'b0, irq}, 8'h00);
      pulse(1'b1, 5'h01, 5'h00);
      check("R6 reset after clear", status, 8'h01);
      check("R10 irq high", {7'b0, irq}, 8'h01);
      // R11: upper write bits are not flags
      reg_write(1'b1, 8'hE0);
      check("R11 upper clear bits", status, 8'h01);

      // R1: mid-run reset clears flags and enables
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      check("R1 reset flags", status, 8'h00);
      pulse(1'b1, 5'h1F, 5'h00);
      check("R1 reset enables", status, 8'h00);
      summary();
   end
endmodule